// File: doc/BRIEF.md
# Fast GPIO Port with Single-Write Bit Operations

This block is a parameterized general-purpose I/O port (16 pins by default) that sits on a simple synchronous register bus. Each pin has its own enable bit and its own direction bit. Together they decide whether the pin drives its stored output value or whether its synchronized input level can be read back through the data register. The block drives an output-enable vector and an output-value vector toward the pads. It takes the raw pad level vector through a synchronizer of configurable depth (two stages by default).

Software changes chosen output bits in one bus write through three write aliases of the data register. The set alias ORs the written word in. The clear alias keeps only the bits written as 1, so a 0 clears that bit. The toggle alias inverts the bits written as 1. None of them needs a read-modify-write sequence, so an interrupting routine can never undo a change.

The bus has no back-pressure. Every write strobe is accepted on the edge that samples it. Every read strobe produces registered data, flagged by a one-cycle valid pulse on the next cycle, and the requester must take it then.

Top module: `fgpio_port`

## Requirements
- R1: After a synchronous reset, the direction, enable and data registers, the synchronizer stages, `pin_oe`, `pin_out`, `rdata` and `rvalid` are all zero.
- R2: The bus offsets are direction at 0x0, data at 0x2 and enable at 0x4. Each is readable and writable. A write to any offset outside {0x0, 0x2, 0x4, 0x6, 0xA, 0xE} changes nothing, and a read of such an offset returns zero.
- R3: `pin_oe[i]` is 1 exactly when enable bit i and direction bit i are both 1. A direction bit of 1 means output and 0 means input.
- R4: `pin_out` always equals the data register. A read of offset 0x2 returns the data register bit for every enabled output pin.
- R5: For an enabled input pin, a read returns the pad level after two synchronizer stages. A read sampled on edge k returns the `pin_in` value that was sampled on edge k-2.
- R6: A write to offset 0xA ORs the written word into the data register.
- R7: A write to offset 0x6 ANDs the written word into the data register. Each 0 bit clears its data bit, and each 1 bit leaves its data bit unchanged.
- R8: A write to offset 0xE XORs the written word into the data register.
- R9: Reads of offsets 0x6, 0xA and 0xE return the same value as a read of offset 0x2. Read bits of disabled pins are undefined.
- R10: Input sampling never alters the data register. A pin that is switched from input back to output drives the value that was stored before.
- R11: A write takes effect on the edge that samples `wr_en`. `rvalid` is high exactly in the cycle after a cycle with `rd_en` high. A read and a write on the same edge return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, sampled each rising edge |
| rd_en | input | 1 | Read strobe, sampled each rising edge |
| addr | input | 4 | Byte offset of the register or alias accessed |
| wdata | input | PIN_W | Write data word |
| rdata | output | PIN_W | Registered read data |
| rvalid | output | 1 | High for one cycle when `rdata` holds a fresh read result |
| pin_in | input | PIN_W | Raw pad input levels, asynchronous to `clk` |
| pin_oe | output | PIN_W | Per-pin output enable toward the pads |
| pin_out | output | PIN_W | Per-pin output value toward the pads |

## Verification
The bench builds the port with its default parameters: 16 pins and a two-stage synchronizer. At 16 bits, alternating nibble and byte patterns reach both halves of every alias operation. The two-stage depth makes the exact read latency from a pad change observable edge by edge. A long random phase mixes writes to every offset, including unmapped and odd ones, with reads and pad changes. It covers enable and direction combinations and same-edge read/write collisions that the directed steps only sample.

// File: rtl/fgpio_pkg.sv
package fgpio_pkg;

  localparam int unsigned OFS_W = 4;

  localparam logic [OFS_W-1:0] OFS_DIR  = 4'h0;
  localparam logic [OFS_W-1:0] OFS_DATA = 4'h2;
  localparam logic [OFS_W-1:0] OFS_ENA  = 4'h4;
  localparam logic [OFS_W-1:0] OFS_CLR  = 4'h6;
  localparam logic [OFS_W-1:0] OFS_SET  = 4'hA;
  localparam logic [OFS_W-1:0] OFS_TOG  = 4'hE;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_DIR,
    ACC_DATA,
    ACC_ENA,
    ACC_CLR,
    ACC_SET,
    ACC_TOG
  } acc_e;

  function automatic acc_e decode_ofs(input logic [OFS_W-1:0] ofs);
    acc_e k;
    case (ofs)
      OFS_DIR:  k = ACC_DIR;
      OFS_DATA: k = ACC_DATA;
      OFS_ENA:  k = ACC_ENA;
      OFS_CLR:  k = ACC_CLR;
      OFS_SET:  k = ACC_SET;
      OFS_TOG:  k = ACC_TOG;
      default:  k = ACC_NONE;
    endcase
    return k;
  endfunction

  function automatic logic is_data_view(input acc_e k);
    return (k == ACC_DATA) || (k == ACC_CLR) || (k == ACC_SET) || (k == ACC_TOG);
  endfunction

endpackage

// File: rtl/fgpio_sync.sv
module fgpio_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  localparam int unsigned LAST = STAGES - 1;

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[LAST];

endmodule

// File: rtl/fgpio_regs.sv
module fgpio_regs
  import fgpio_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  acc_e         acc,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] ena_q,
  output logic [W-1:0] dat_q
);

  logic [W-1:0] dat_nxt;

  always_comb begin
    dat_nxt = dat_q;
    case (acc)
      ACC_DATA: dat_nxt = wdata;
      ACC_SET:  dat_nxt = dat_q | wdata;
      ACC_CLR:  dat_nxt = dat_q & wdata;
      ACC_TOG:  dat_nxt = dat_q ^ wdata;
      default:  dat_nxt = dat_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      ena_q <= '0;
      dat_q <= '0;
    end else if (wr_en) begin
      if (acc == ACC_DIR) dir_q <= wdata;
      if (acc == ACC_ENA) ena_q <= wdata;
      dat_q <= dat_nxt;
    end
  end

endmodule

// File: rtl/fgpio_rdpath.sv
module fgpio_rdpath
  import fgpio_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_en,
  input  acc_e         acc,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] ena_q,
  input  logic [W-1:0] dat_q,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] rdata,
  output logic         rvalid
);

  logic [W-1:0] live;
  logic [W-1:0] rd_val;

  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    assign live[gi] = (ena_q[gi] & ~dir_q[gi]) ? pin_sync[gi] : dat_q[gi];
  end

  always_comb begin
    if (is_data_view(acc))   rd_val = live;
    else if (acc == ACC_DIR) rd_val = dir_q;
    else if (acc == ACC_ENA) rd_val = ena_q;
    else                     rd_val = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_val;
    end
  end

endmodule

// File: rtl/fgpio_port.sv
module fgpio_port
  import fgpio_pkg::*;
#(
  parameter int unsigned PIN_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [OFS_W-1:0] addr,
  input  logic [PIN_W-1:0] wdata,
  output logic [PIN_W-1:0] rdata,
  output logic             rvalid,
  input  logic [PIN_W-1:0] pin_in,
  output logic [PIN_W-1:0] pin_oe,
  output logic [PIN_W-1:0] pin_out
);

  acc_e             acc;
  logic [PIN_W-1:0] dir_q;
  logic [PIN_W-1:0] ena_q;
  logic [PIN_W-1:0] dat_q;
  logic [PIN_W-1:0] pin_sync;

  assign acc = decode_ofs(addr);

  fgpio_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pin_in),
    .dout (pin_sync)
  );

  fgpio_regs #(.W(PIN_W)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .acc   (acc),
    .wdata (wdata),
    .dir_q (dir_q),
    .ena_q (ena_q),
    .dat_q (dat_q)
  );

  fgpio_rdpath #(.W(PIN_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .acc      (acc),
    .dir_q    (dir_q),
    .ena_q    (ena_q),
    .dat_q    (dat_q),
    .pin_sync (pin_sync),
    .rdata    (rdata),
    .rvalid   (rvalid)
  );

  assign pin_oe  = ena_q & dir_q;
  assign pin_out = dat_q;

endmodule

// File: rtl/fgpio_port_chk.sv
module fgpio_port_chk
  import fgpio_pkg::*;
#(
  parameter int unsigned PIN_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             rd_en,
  input logic [OFS_W-1:0] addr,
  input logic [PIN_W-1:0] wdata,
  input logic             rvalid,
  input logic [PIN_W-1:0] pin_oe,
  input logic [PIN_W-1:0] pin_out
);

  logic data_wr;
  assign data_wr = wr_en && (addr == OFS_DATA || addr == OFS_CLR ||
                             addr == OFS_SET  || addr == OFS_TOG);

  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_oe == '0 && pin_out == '0 && !rvalid));

  assert_dir_clear_drops_oe_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_DIR) |=> ((pin_oe & ~$past(wdata)) == '0));

  assert_set_alias_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_SET) |=> ((pin_out & $past(wdata)) == $past(wdata)));

  assert_clr_alias_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_CLR) |=> ((pin_out & ~$past(wdata)) == '0));

  assert_tog_alias_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_TOG) |=> (pin_out == ($past(pin_out) ^ $past(wdata))));

  assert_data_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !data_wr |=> $stable(pin_out));

  assert_rvalid_follows_R11: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid);

  assert_rvalid_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rvalid);

endmodule

bind fgpio_port fgpio_port_chk #(.PIN_W(PIN_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .wdata   (wdata),
  .rvalid  (rvalid),
  .pin_oe  (pin_oe),
  .pin_out (pin_out)
);

// File: tb/fgpio_port_bench.sv
`timescale 1ns/1ps
module fgpio_port_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] pin_in = '0;
  logic [15:0] rdata;
  logic        rvalid;
  logic [15:0] pin_oe;
  logic [15:0] pin_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  fgpio_port u_fgpio_port (
    .clk (clk), .rst (rst), .wr_en (wr_en), .rd_en (rd_en), .addr (addr),
    .wdata (wdata), .rdata (rdata), .rvalid (rvalid), .pin_in (pin_in),
    .pin_oe (pin_oe), .pin_out (pin_out)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model, updated behaviourally on every rising edge
  logic [15:0] m_dir, m_en, m_data, m_s1, m_s2, m_rval, m_rmask;
  logic        m_rvalid, m_live;

  always @(posedge clk) begin
    if (rst) begin
      m_dir = 0; m_en = 0; m_data = 0; m_s1 = 0; m_s2 = 0;
      m_rval = 0; m_rmask = 16'hFFFF; m_rvalid = 0; m_live = 0;
    end else begin
      m_live = 1;
      m_rvalid = rd_en;
      if (rd_en) begin
        case (addr)
          4'h0: begin m_rval = m_dir; m_rmask = 16'hFFFF; end
          4'h4: begin m_rval = m_en;  m_rmask = 16'hFFFF; end
          4'h2, 4'h6, 4'hA, 4'hE: begin
            m_rval  = (m_en & ~m_dir & m_s2) | (m_en & m_dir & m_data);
            m_rmask = m_en;
          end
          default: begin m_rval = 0; m_rmask = 16'hFFFF; end
        endcase
      end
      m_s2 = m_s1;
      m_s1 = pin_in;
      if (wr_en) begin
        case (addr)
          4'h0: m_dir = wdata;
          4'h2: m_data = wdata;
          4'h4: m_en = wdata;
          4'h6: m_data = m_data & wdata;
          4'hA: m_data = m_data | wdata;
          4'hE: m_data = m_data ^ wdata;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (m_live) begin
      chk("R3 model pin_oe", pin_oe, m_en & m_dir);
      chk("R4 model pin_out", pin_out, m_data);
      chk("R11 model rvalid", {15'd0, rvalid}, {15'd0, m_rvalid});
      if (m_rvalid) chk("R2 model rdata", rdata & m_rmask, m_rval & m_rmask);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 pin_oe", pin_oe, 16'h0);
    chk("R1 pin_out", pin_out, 16'h0);
    rd(4'h0, v); chk("R1 dir", v, 16'h0);
    rd(4'h2, v); chk("R1 data", v, 16'h0);
    rd(4'h4, v); chk("R1 enable", v, 16'h0);
    // R3/R4 outputs
    wr(4'h0, 16'hFFFF); wr(4'h4, 16'hFFFF); wr(4'h2, 16'hA5A5);
    rd(4'h2, v); chk("R4 data read", v, 16'hA5A5);
    chk("R4 pin_out", pin_out, 16'hA5A5);
    chk("R3 pin_oe all", pin_oe, 16'hFFFF);
    // R6 set, R9 alias read
    wr(4'hA, 16'h0F0F);
    chk("R6 set", pin_out, 16'hAFAF);
    rd(4'hA, v); chk("R9 set alias read", v, 16'hAFAF);
    // R7 clear (zeros clear)
    wr(4'h6, 16'hFF00);
    chk("R7 clear", pin_out, 16'hAF00);
    rd(4'h6, v); chk("R9 clr alias read", v, 16'hAF00);
    // R8 toggle
    wr(4'hE, 16'h0FF0);
    chk("R8 toggle", pin_out, 16'hA0F0);
    rd(4'hE, v); chk("R9 tog alias read", v, 16'hA0F0);
    // R3 enable and direction combine
    wr(4'h4, 16'h00FF); wr(4'h0, 16'h0F0F);
    chk("R3 pin_oe mixed", pin_oe, 16'h000F);
    // R5/R10 inputs
    wr(4'h4, 16'hFFFF); wr(4'h0, 16'h0000);
    pin_in = 16'h1234;
    repeat (3) @(negedge clk);
    rd(4'h2, v); chk("R5 input read", v, 16'h1234);
    chk("R10 pin_out kept", pin_out, 16'hA0F0);
    chk("R3 pin_oe inputs", pin_oe, 16'h0000);
    // R5 synchronizer latency
    pin_in = 16'h0000;
    repeat (3) @(negedge clk);
    pin_in = 16'hFFFF; rd_en = 1; addr = 4'h2;
    @(negedge clk); chk("R5 latency edge1", rdata, 16'h0000);
    @(negedge clk); chk("R5 latency edge2", rdata, 16'h0000);
    @(negedge clk); chk("R5 latency edge3", rdata, 16'hFFFF);
    rd_en = 0;
    wr(4'h0, 16'hFFFF);
    rd(4'h2, v); chk("R10 restored output", v, 16'hA0F0);
    // R2 unmapped offsets
    wr(4'h8, 16'hFFFF); wr(4'h3, 16'h0000);
    rd(4'h2, v); chk("R2 unmapped write data", v, 16'hA0F0);
    rd(4'h0, v); chk("R2 unmapped write dir", v, 16'hFFFF);
    rd(4'hC, v); chk("R2 unmapped read", v, 16'h0000);
    // R11 same-edge read and write
    @(negedge clk); wr_en = 1; rd_en = 1; addr = 4'h2; wdata = 16'h5555;
    @(negedge clk); wr_en = 0; rd_en = 0;
    chk("R11 read before write", rdata, 16'hA0F0);
    chk("R11 write applied", pin_out, 16'h5555);
    // random phase, checked by the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      wr_en = ($urandom % 3) == 0;
      rd_en = ($urandom % 2) == 0;
      addr  = 4'($urandom % 16);
      wdata = 16'($urandom);
      if (($urandom % 4) == 0) pin_in = 16'($urandom);
    end
    @(negedge clk); wr_en = 0; rd_en = 0;
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule